// File: doc/BRIEF.md
# USB OUT Endpoint Handshake Controller

This block sits behind a simplified serial interface engine on a USB device and decides, for every OUT transaction, whether the data phase is stored and which handshake goes back to the host. The engine presents an OUT token with its endpoint number, then a stream of payload bytes, then an end-of-data-phase strobe for a good packet. The block checks the endpoint's enable and type bits and its buffer-full state. An empty buffer on an enabled endpoint takes the payload and the block answers ACK. A full buffer drops the payload and the block answers NAK. An isochronous endpoint never gets a handshake.

Each endpoint owns a small byte buffer with a stored byte count, a full bit and an overflow bit. Packets longer than the buffer keep only their first bytes, and the overflow is flagged. When a packet is taken, the endpoint's interrupt flag is raised and drives the interrupt output. Firmware reads the flag register, which clears it, and selects an endpoint to see its status. It then pulls the bytes out one at a time and frees the buffer with a clear strobe, so the next OUT token can be accepted.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: An OUT transaction addressed to an endpoint whose bit in `ep_en_i` is 0 returns no handshake, sets no interrupt flag and leaves that endpoint's status (full 0, count 0) unchanged.
- R2: For an enabled non-isochronous endpoint with an empty buffer, the payload bytes are stored and the byte count is recorded. `hs_valid_o` is high for exactly one cycle, in the cycle after the edge that samples `data_end_i`, with `hs_nak_o` = 0 (ACK).
- R3: For an enabled non-isochronous endpoint whose buffer is full, the payload is discarded. The handshake comes at the same time as an ACK would, with `hs_nak_o` = 1 (NAK). Stored bytes, count and interrupt flags stay unchanged.
- R4: For an enabled isochronous endpoint (bit set in `ep_iso_i`) with an empty buffer, the payload is stored and no handshake is produced. Its interrupt flag reads 1 right after the edge that samples `data_end_i`.
- R5: For an accepted non-isochronous packet, the interrupt flag is still 0 during the handshake cycle and reads 1 one cycle later. Full, count and overflow bits are already updated during the handshake cycle.
- R6: `irq_o` is the OR of `int_flags_o`, where bit n belongs to endpoint n. A flag stays set until a cycle with `int_rd_i` = 1, which clears all flags. A flag set in that same cycle survives the clear.
- R7: The full bit of an endpoint sets when a packet is accepted and clears only on a `buf_clr_i` strobe with that endpoint selected on `cpu_ep_i`. That strobe also zeroes the count, the overflow bit and the read pointer. After it, the next OUT is accepted again.
- R8: A packet of more than DEPTH bytes stores only its first DEPTH bytes, gives a count of DEPTH and sets the overflow bit. A packet of exactly DEPTH bytes leaves the overflow bit at 0.
- R9: `buf_rdata_o` shows the byte at the read pointer of the selected endpoint, starting from the first payload byte. Each `buf_rd_i` strobe advances the pointer by one.
- R10: After reset all interrupt flags, `irq_o` and `hs_valid_o` are 0, and every endpoint reads full 0, count 0, overflow 0.
- R11: An OUT to an isochronous endpoint whose buffer is full returns no handshake, sets no flag and leaves the stored bytes and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_out_i | input | 1 | OUT token strobe, one cycle |
| tok_ep_i | input | EP_W | Endpoint addressed by the token |
| data_valid_i | input | 1 | Payload byte strobe |
| data_i | input | 8 | Payload byte |
| data_end_i | input | 1 | End of a good data phase, one cycle |
| ep_en_i | input | N_EP | Per-endpoint enable |
| ep_iso_i | input | N_EP | Per-endpoint isochronous type |
| hs_valid_o | output | 1 | Handshake request to the engine, one cycle |
| hs_nak_o | output | 1 | Handshake code: 0 ACK, 1 NAK |
| int_flags_o | output | N_EP | Per-endpoint interrupt flags |
| irq_o | output | 1 | Interrupt to the processor |
| int_rd_i | input | 1 | Flag register read, clears the flags |
| cpu_ep_i | input | EP_W | Endpoint selected by the processor |
| st_full_o | output | 1 | Selected endpoint buffer full |
| st_cnt_o | output | CNT_W | Selected endpoint stored byte count |
| st_err_o | output | 1 | Selected endpoint overflow |
| buf_rd_i | input | 1 | Advance the selected read pointer |
| buf_rdata_o | output | 8 | Byte at the selected read pointer |
| buf_clr_i | input | 1 | Free the selected endpoint buffer |

## Verification
The assertions watch, on every cycle, the properties that can be seen from the ports alone. A handshake is always one cycle long and directly follows an end-of-data strobe. The interrupt output always matches the flags. Flags never drop without a read. A full buffer never empties without a clear strobe. The count never goes past the buffer depth. The ACK versus NAK choice, silence for disabled and isochronous endpoints, the one-cycle gap between ACK and the flag, set winning over clear, truncation at the depth boundary and the byte order seen through the read port all depend on what came before. Only the bench's scenarios, with their scoreboard of expected handshakes, can show them.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_DROP,
    ST_SKIP,
    ST_HS
  } rx_state_e;
endpackage

// File: rtl/usb_out_rx_fsm.sv
module usb_out_rx_fsm
  import usb_out_ep_pkg::*;
#(
  parameter int N_EP  = 4,
  parameter int DEPTH = 8,
  localparam int EP_W  = $clog2(N_EP),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tok_out_i,
  input  logic [EP_W-1:0]  tok_ep_i,
  input  logic             data_valid_i,
  input  logic [7:0]       data_i,
  input  logic             data_end_i,
  input  logic [N_EP-1:0]  ep_en_i,
  input  logic [N_EP-1:0]  ep_iso_i,
  input  logic [N_EP-1:0]  ep_full_i,
  output logic             wr_en_o,
  output logic [EP_W-1:0]  wr_ep_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic             commit_o,
  output logic [EP_W-1:0]  commit_ep_o,
  output logic [CNT_W-1:0] commit_cnt_o,
  output logic             commit_err_o,
  output logic [N_EP-1:0]  int_set_o,
  output logic             hs_valid_o,
  output logic             hs_nak_o
);
  rx_state_e        state_q;
  logic [EP_W-1:0]  ep_q;
  logic             iso_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             hs_valid_q, hs_nak_q;
  logic             room;

  assign room = cnt_q < CNT_W'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ep_q       <= '0;
      iso_q      <= 1'b0;
      cnt_q      <= '0;
      ovf_q      <= 1'b0;
      hs_valid_q <= 1'b0;
      hs_nak_q   <= 1'b0;
    end else begin
      hs_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (tok_out_i) begin
          ep_q  <= tok_ep_i;
          iso_q <= ep_iso_i[tok_ep_i];
          cnt_q <= '0;
          ovf_q <= 1'b0;
          if (!ep_en_i[tok_ep_i])      state_q <= ST_SKIP;
          else if (ep_full_i[tok_ep_i]) state_q <= ST_DROP;
          else                          state_q <= ST_RECV;
        end
        ST_RECV: begin
          if (data_end_i) begin
            state_q <= iso_q ? ST_IDLE : ST_HS;
            if (!iso_q) begin
              hs_valid_q <= 1'b1;
              hs_nak_q   <= 1'b0;
            end
          end else if (data_valid_i) begin
            if (room) cnt_q <= cnt_q + 1'b1;
            else      ovf_q <= 1'b1;
          end
        end
        ST_DROP: if (data_end_i) begin
          state_q <= ST_IDLE;
          if (!iso_q) begin
            hs_valid_q <= 1'b1;
            hs_nak_q   <= 1'b1;
          end
        end
        ST_SKIP: if (data_end_i) state_q <= ST_IDLE;
        ST_HS:   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_en_o      = (state_q == ST_RECV) && data_valid_i && !data_end_i && room;
  assign wr_ep_o      = ep_q;
  assign wr_addr_o    = cnt_q[PTR_W-1:0];
  assign wr_data_o    = data_i;
  assign commit_o     = (state_q == ST_RECV) && data_end_i;
  assign commit_ep_o  = ep_q;
  assign commit_cnt_o = cnt_q;
  assign commit_err_o = ovf_q;
  assign hs_valid_o   = hs_valid_q;
  assign hs_nak_o     = hs_nak_q;

  // iso flags on data arrival, others one cycle after the ACK is issued
  always_comb begin
    int_set_o = '0;
    if ((commit_o && iso_q) || state_q == ST_HS) int_set_o[ep_q] = 1'b1;
  end
endmodule

// File: rtl/usb_ep_store.sv
module usb_ep_store #(
  parameter int N_EP  = 4,
  parameter int DEPTH = 8,
  localparam int EP_W  = $clog2(N_EP),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int MEM_N = N_EP * DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [EP_W-1:0]  wr_ep_i,
  input  logic [PTR_W-1:0] wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             commit_i,
  input  logic [EP_W-1:0]  commit_ep_i,
  input  logic [CNT_W-1:0] commit_cnt_i,
  input  logic             commit_err_i,
  input  logic [EP_W-1:0]  cpu_ep_i,
  input  logic             buf_rd_i,
  input  logic             buf_clr_i,
  output logic [N_EP-1:0]  full_o,
  output logic             st_full_o,
  output logic [CNT_W-1:0] st_cnt_o,
  output logic             st_err_o,
  output logic [7:0]       rdata_o
);
  logic [7:0]       mem_q  [MEM_N];
  logic             full_q [N_EP];
  logic             err_q  [N_EP];
  logic [CNT_W-1:0] cnt_q  [N_EP];
  logic [PTR_W-1:0] rptr_q [N_EP];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[{wr_ep_i, wr_addr_i}] <= wr_data_i;
  end

  for (genvar e = 0; e < N_EP; e++) begin : g_ep
    logic hit_commit, hit_cpu;
    assign hit_commit = commit_i && (commit_ep_i == EP_W'(e));
    assign hit_cpu    = cpu_ep_i == EP_W'(e);

    // commit wins over a clear of the same endpoint
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_q[e] <= 1'b0;
        err_q[e]  <= 1'b0;
        cnt_q[e]  <= '0;
        rptr_q[e] <= '0;
      end else if (hit_commit) begin
        full_q[e] <= 1'b1;
        err_q[e]  <= commit_err_i;
        cnt_q[e]  <= commit_cnt_i;
        rptr_q[e] <= '0;
      end else if (buf_clr_i && hit_cpu) begin
        full_q[e] <= 1'b0;
        err_q[e]  <= 1'b0;
        cnt_q[e]  <= '0;
        rptr_q[e] <= '0;
      end else if (buf_rd_i && hit_cpu) begin
        rptr_q[e] <= rptr_q[e] + 1'b1;
      end
    end

    assign full_o[e] = full_q[e];
  end

  assign st_full_o = full_q[cpu_ep_i];
  assign st_cnt_o  = cnt_q[cpu_ep_i];
  assign st_err_o  = err_q[cpu_ep_i];
  assign rdata_o   = mem_q[{cpu_ep_i, rptr_q[cpu_ep_i]}];
endmodule

// File: rtl/usb_out_irq.sv
module usb_out_irq #(
  parameter int N_EP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_EP-1:0] set_i,
  input  logic            rd_i,
  output logic [N_EP-1:0] flags_o,
  output logic            irq_o
);
  logic [N_EP-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (rd_i ? '0 : flags_q) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |flags_q;
endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl #(
  parameter int N_EP  = 4,
  parameter int DEPTH = 8,
  localparam int EP_W  = $clog2(N_EP),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tok_out_i,
  input  logic [EP_W-1:0]  tok_ep_i,
  input  logic             data_valid_i,
  input  logic [7:0]       data_i,
  input  logic             data_end_i,
  input  logic [N_EP-1:0]  ep_en_i,
  input  logic [N_EP-1:0]  ep_iso_i,
  output logic             hs_valid_o,
  output logic             hs_nak_o,
  output logic [N_EP-1:0]  int_flags_o,
  output logic             irq_o,
  input  logic             int_rd_i,
  input  logic [EP_W-1:0]  cpu_ep_i,
  output logic             st_full_o,
  output logic [CNT_W-1:0] st_cnt_o,
  output logic             st_err_o,
  input  logic             buf_rd_i,
  output logic [7:0]       buf_rdata_o,
  input  logic             buf_clr_i
);
  logic             wr_en, commit, commit_err;
  logic [EP_W-1:0]  wr_ep, commit_ep;
  logic [PTR_W-1:0] wr_addr;
  logic [7:0]       wr_data;
  logic [CNT_W-1:0] commit_cnt;
  logic [N_EP-1:0]  ep_full, int_set;

  usb_out_rx_fsm #(.N_EP(N_EP), .DEPTH(DEPTH)) u_fsm (
    .clk_i, .rst_ni, .tok_out_i, .tok_ep_i, .data_valid_i, .data_i, .data_end_i,
    .ep_en_i, .ep_iso_i,
    .ep_full_i    (ep_full),
    .wr_en_o      (wr_en),
    .wr_ep_o      (wr_ep),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .commit_o     (commit),
    .commit_ep_o  (commit_ep),
    .commit_cnt_o (commit_cnt),
    .commit_err_o (commit_err),
    .int_set_o    (int_set),
    .hs_valid_o,
    .hs_nak_o
  );

  usb_ep_store #(.N_EP(N_EP), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i      (wr_en),
    .wr_ep_i      (wr_ep),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .commit_i     (commit),
    .commit_ep_i  (commit_ep),
    .commit_cnt_i (commit_cnt),
    .commit_err_i (commit_err),
    .cpu_ep_i, .buf_rd_i, .buf_clr_i,
    .full_o       (ep_full),
    .st_full_o, .st_cnt_o, .st_err_o,
    .rdata_o      (buf_rdata_o)
  );

  usb_out_irq #(.N_EP(N_EP)) u_irq (
    .clk_i, .rst_ni,
    .set_i   (int_set),
    .rd_i    (int_rd_i),
    .flags_o (int_flags_o),
    .irq_o
  );
endmodule

// File: rtl/usb_out_ep_ctrl_chk.sv
module usb_out_ep_ctrl_chk #(
  parameter int N_EP  = 4,
  parameter int DEPTH = 8,
  localparam int EP_W  = $clog2(N_EP),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             data_end_i,
  input logic             hs_valid_o,
  input logic             int_rd_i,
  input logic [N_EP-1:0]  int_flags_o,
  input logic             irq_o,
  input logic             buf_clr_i,
  input logic [EP_W-1:0]  cpu_ep_i,
  input logic             st_full_o,
  input logic [CNT_W-1:0] st_cnt_o
);
  a_r2_hs_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |-> $past(data_end_i));

  a_r2_hs_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |=> !hs_valid_o);

  a_r6_irq_any: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (int_flags_o != '0));

  a_r6_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_rd_i |=> ((int_flags_o & $past(int_flags_o)) == $past(int_flags_o)));

  a_r7_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_full_o && !buf_clr_i) |=> (st_full_o || cpu_ep_i != $past(cpu_ep_i)));

  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_cnt_o <= CNT_W'(DEPTH));
endmodule

bind usb_out_ep_ctrl usb_out_ep_ctrl_chk #(.N_EP(N_EP), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/usb_out_ep_ctrl_tb_top.sv
module usb_out_ep_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_EP  = 4;
  localparam int DEPTH = 8;
  localparam int EP_W  = $clog2(N_EP);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic tok_out = 1'b0, data_valid = 1'b0, data_end = 1'b0;
  logic [EP_W-1:0] tok_ep = '0, cpu_ep = '0;
  logic [7:0] data = '0;
  logic [N_EP-1:0] ep_en = 4'b1011, ep_iso = 4'b0010;
  logic int_rd = 1'b0, buf_rd = 1'b0, buf_clr = 1'b0;
  logic hs_valid, hs_nak, irq, st_full, st_err;
  logic [N_EP-1:0] flags;
  logic [CNT_W-1:0] st_cnt;
  logic [7:0] rdata;

  int checks = 0, errors = 0;
  bit hs_exp_q[$];  // 1 = NAK expected

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_out_ep_ctrl #(.N_EP(N_EP), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tok_out_i(tok_out), .tok_ep_i(tok_ep),
    .data_valid_i(data_valid), .data_i(data), .data_end_i(data_end),
    .ep_en_i(ep_en), .ep_iso_i(ep_iso), .hs_valid_o(hs_valid), .hs_nak_o(hs_nak),
    .int_flags_o(flags), .irq_o(irq), .int_rd_i(int_rd), .cpu_ep_i(cpu_ep),
    .st_full_o(st_full), .st_cnt_o(st_cnt), .st_err_o(st_err),
    .buf_rd_i(buf_rd), .buf_rdata_o(rdata), .buf_clr_i(buf_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // handshake monitor: R1/R4/R11 expect none, R2 ACK, R3 NAK
  always @(negedge clk) begin
    if (rst_n && hs_valid) begin
      if (hs_exp_q.size() == 0) begin
        chk("R1 unexpected handshake", 1, 0);
      end else begin
        bit e;
        e = hs_exp_q.pop_front();
        chk("R2 handshake code", int'(hs_nak), int'(e));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // hs: 0 none, 1 ACK, 2 NAK
  task automatic send_out(input int ep, input int n, input int base, input int hs, input bit rd_at_end);
    @(negedge clk);
    tok_out = 1'b1;
    tok_ep  = EP_W'(ep);
    if (hs == 1) hs_exp_q.push_back(1'b0);
    if (hs == 2) hs_exp_q.push_back(1'b1);
    @(negedge clk);
    tok_out = 1'b0;
    for (int i = 0; i < n; i++) begin
      data_valid = 1'b1;
      data = 8'(base + i);
      @(negedge clk);
    end
    data_valid = 1'b0;
    data_end   = 1'b1;
    int_rd     = rd_at_end;
    @(negedge clk);
    data_end = 1'b0;
    int_rd   = 1'b0;
  endtask

  task automatic pulse_rd_flags();
    int_rd = 1'b1;
    @(negedge clk);
    int_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    buf_clr = 1'b1;
    @(negedge clk);
    buf_clr = 1'b0;
  endtask

  task automatic read_bytes(input string req, input int n, input int base);
    for (int i = 0; i < n; i++) begin
      chk(req, int'(rdata), (base + i) & 8'hff);
      buf_rd = 1'b1;
      @(negedge clk);
      buf_rd = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL R10 watchdog expired act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R10 reset state
    chk("R10 irq", int'(irq), 0);
    chk("R10 flags", int'(flags), 0);
    chk("R10 hs_valid", int'(hs_valid), 0);
    for (int e = 0; e < N_EP; e++) begin
      cpu_ep = EP_W'(e);
      #1;
      chk("R10 full", int'(st_full), 0);
      chk("R10 cnt", int'(st_cnt), 0);
      chk("R10 err", int'(st_err), 0);
    end

    // R1 disabled endpoint 2
    send_out(2, 3, 8'h30, 0, 1'b0);
    tick(3);
    chk("R1 flags", int'(flags), 0);
    cpu_ep = 2'd2;
    #1;
    chk("R1 full", int'(st_full), 0);
    chk("R1 cnt", int'(st_cnt), 0);

    // R2/R5 accepted on empty ep0
    send_out(0, 5, 8'h10, 1, 1'b0);
    chk("R5 flag during handshake", int'(flags[0]), 0);
    cpu_ep = 2'd0;
    #1;
    chk("R5 full during handshake", int'(st_full), 1);
    tick(1);
    chk("R5 flag after handshake", int'(flags[0]), 1);
    chk("R6 irq", int'(irq), 1);
    chk("R2 full", int'(st_full), 1);
    chk("R2 cnt", int'(st_cnt), 5);
    chk("R2 err", int'(st_err), 0);

    // R6 clear on read
    pulse_rd_flags();
    chk("R6 flags cleared", int'(flags), 0);
    chk("R6 irq cleared", int'(irq), 0);

    // R3 NAK on full ep0
    send_out(0, 4, 8'h80, 2, 1'b0);
    tick(2);
    chk("R3 flags", int'(flags), 0);
    chk("R3 cnt", int'(st_cnt), 5);
    chk("R3 full", int'(st_full), 1);

    // R9 byte read-out; contents prove R3 did not overwrite
    read_bytes("R9 rdata", 5, 8'h10);
    chk("R7 full after reading", int'(st_full), 1);

    // R7 clear strobe then new acceptance
    pulse_clr();
    chk("R7 full cleared", int'(st_full), 0);
    chk("R7 cnt cleared", int'(st_cnt), 0);
    send_out(0, 2, 8'h50, 1, 1'b0);
    tick(1);
    chk("R7 full again", int'(st_full), 1);
    chk("R7 cnt again", int'(st_cnt), 2);
    chk("R7 flag0", int'(flags[0]), 1);

    // R4 iso ep1, read in the same cycle: set wins (R6)
    send_out(1, 3, 8'h60, 0, 1'b1);
    chk("R4 flag immediate, R6 set wins", int'(flags), 4'b0010);
    cpu_ep = 2'd1;
    #1;
    chk("R4 full", int'(st_full), 1);
    chk("R4 cnt", int'(st_cnt), 3);

    // R11 iso to full ep1
    pulse_rd_flags();
    send_out(1, 2, 8'h70, 0, 1'b0);
    tick(2);
    chk("R11 flags", int'(flags), 0);
    chk("R11 cnt", int'(st_cnt), 3);
    chk("R11 rdata", int'(rdata), 8'h60);

    // R8 truncation on ep3
    send_out(3, 11, 8'hA0, 1, 1'b0);
    tick(1);
    cpu_ep = 2'd3;
    #1;
    chk("R8 cnt truncated", int'(st_cnt), DEPTH);
    chk("R8 err", int'(st_err), 1);
    chk("R8 full", int'(st_full), 1);
    read_bytes("R8 rdata", DEPTH, 8'hA0);

    // R8 exactly DEPTH bytes on ep0
    cpu_ep = 2'd0;
    pulse_clr();
    send_out(0, DEPTH, 8'hC0, 1, 1'b0);
    tick(1);
    chk("R8 exact cnt", int'(st_cnt), DEPTH);
    chk("R8 exact err", int'(st_err), 0);
    read_bytes("R8 exact rdata", DEPTH, 8'hC0);

    tick(3);
    chk("R2 missing handshakes", hs_exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule